// File: doc/BRIEF.md
# Multi-Level Radix Translation Walker

This block translates an effective address into a real address by walking a radix tree kept in memory. A request supplies the effective address, the base and index width of the root directory, the number of address bits the tree covers, the access kind, the privilege state and a three-bit key-deny mask. The walker then fetches one 64-bit entry per level. Every non-leaf entry carries the base and index width of the next level, so the depth of the walk and the resulting page size follow the data in memory.

At a leaf, the entry passes through a permission check. If the check succeeds, the walker forms the real address and the page-size exponent. It then sets the referenced bit, and also the changed bit on a write. The updated entry goes back to memory only when it differs from the value read. The result is a one-cycle `done` pulse. It carries either the translation and its rights or a fault cause word. Memory is reached through a pulsed read request with a later read-valid return, and a pulsed write request with a later acknowledge.

Top module: `rwalk_top`

## Requirements
- R1: The entry of a level is read at base + 8 × ((ea >> (remaining − width)) & (2^width − 1)), where width is the index width of that level and remaining is the count of untranslated address bits, which starts at `addr_bits`.
- R2: A level index width below 5 ends the walk with cause 0x00080000 and issues no read for that level.
- R3: A level index width larger than the remaining bit count ends the walk with cause 0x00080000 and issues no read for that level.
- R4: At most 8 entries are read in one walk. If a ninth level would be needed, the walk ends with cause 0x00080000.
- R5: An entry whose bit 63 is clear ends the walk with cause 0x40000000.
- R6: A valid entry with bit 62 clear is a pointer. The next base is entry & 0x0FFFFFFFFFFFFF00, the next index width is entry bits 4:0, and the remaining count drops by the current width.
- R7: A valid entry with bit 62 set is a leaf. The real address takes bits from entry & 0x01FFFFFFFFFFF000 above the remaining count and ea bits below it. `page_exp` equals the remaining count.
- R8: Leaf rights come from entry bits 3:0: bit 3 privileged-only, bit 2 read, bit 1 read and write, bit 0 execute. A user-mode access to a privileged page gets no rights. A supervisor access to a non-privileged page loses the rights set in `key_deny` {read, write, execute}. If the access kind (0 read, 1 write, 2 execute) lacks its right, the cause is 0x08000000. `perm` is {read, write, execute}.
- R9: An execute access to a leaf whose bits 5:4 equal 2'b10 fails with cause 0x10000000.
- R10: On success the written entry has bit 8 set, and bit 7 is also set on a write. On a non-write access, `perm` has its write bit cleared.
- R11: The updated entry is written back to the leaf's address only when it differs from the entry read. A walk that faults never writes.
- R12: `done` is a one-cycle pulse. On a fault, `perm`, `real_addr` and `page_exp` are zero and `cause` is nonzero. On success, `cause` is zero. After reset, `done`, `rd_req` and `wr_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken when idle) |
| ea | input | 64 | Effective address |
| root_base | input | 64 | Base address of the root directory |
| root_bits | input | 5 | Index width of the root directory |
| addr_bits | input | 6 | Address bits covered by the tree |
| access | input | 2 | 0 read, 1 write, 2 execute |
| user_mode | input | 1 | Access made in user mode |
| key_deny | input | 3 | Supervisor deny mask {read, write, execute} |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | 64 | Entry read address |
| rd_valid | input | 1 | Read data return strobe |
| rd_data | input | 64 | Entry read data |
| wr_req | output | 1 | Write-back request pulse |
| wr_addr | output | 64 | Write-back address |
| wr_data | output | 64 | Updated entry |
| wr_ack | input | 1 | Write-back completion strobe |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Walk ended in a fault |
| cause | output | 32 | Fault cause word |
| real_addr | output | 64 | Translated address |
| page_exp | output | 6 | Log2 of page size |
| perm | output | 3 | Granted rights {read, write, execute} |

## Verification
The leaf cycle holds two decisions at once: the permission verdict and the choice of whether the referenced and changed bits need a write-back. A leaf can both fail its check and have bits that would change. Directed cases provoke this, such as a write to a read-only page whose referenced bit is clear, and random leaves with arbitrary rights and R/C bits do so repeatedly. The bench judges these walks by the fault cause together with the absence of any write request, and judges successful leaves by the presence or absence of exactly one write with the expected data.

// File: rtl/rwalk_pkg.sv
package rwalk_pkg;
  localparam int ENT_W = 64;
  localparam int LVL_W = 5;

  localparam int BIT_VALID = 63;
  localparam int BIT_LEAF  = 62;
  localparam int BIT_REF   = 8;
  localparam int BIT_CHG   = 7;

  localparam logic [ENT_W-1:0] PAGE_NUM_MASK  = 64'h01FF_FFFF_FFFF_F000;
  localparam logic [ENT_W-1:0] NEXT_BASE_MASK = 64'h0FFF_FFFF_FFFF_FF00;

  localparam logic [31:0] CAUSE_BADCFG = 32'h0008_0000;
  localparam logic [31:0] CAUSE_NOENT  = 32'h4000_0000;
  localparam logic [31:0] CAUSE_PROT   = 32'h0800_0000;
  localparam logic [31:0] CAUSE_GUARD  = 32'h1000_0000;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [1:0] ATT_NONIDEM = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WAIT,
    ST_EVAL,
    ST_WB
  } walk_st_e;
endpackage

// File: rtl/rwalk_index.sv
module rwalk_index
  import rwalk_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int MIN_BITS = 5
) (
  input  logic [ADDR_W-1:0]         ea,
  input  logic [ADDR_W-1:0]         base,
  input  logic [LVL_W-1:0]          lvl_bits,
  input  logic [$clog2(ADDR_W)-1:0] rem_bits,
  output logic [ADDR_W-1:0]         ent_addr,
  output logic                      cfg_bad
);
  localparam int SW = $clog2(ADDR_W);

  logic [SW-1:0]     shamt;
  logic [ADDR_W-1:0] idx_mask;
  logic [ADDR_W-1:0] idx;

  always_comb begin
    cfg_bad  = (lvl_bits < LVL_W'(MIN_BITS)) || (SW'(lvl_bits) > rem_bits);
    shamt    = rem_bits - SW'(lvl_bits);
    idx_mask = (ADDR_W'(1) << lvl_bits) - ADDR_W'(1);
    idx      = (ea >> shamt) & idx_mask;
    ent_addr = base + (idx << 3);
  end
endmodule

// File: rtl/rwalk_perm.sv
module rwalk_perm
  import rwalk_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  logic [1:0]       access,
  input  logic             user_mode,
  input  logic [2:0]       key_deny,
  output logic             deny,
  output logic [31:0]      deny_cause,
  output logic [2:0]       rights
);
  logic       priv_pg;
  logic [2:0] base_rights;
  logic [2:0] need;
  logic       guard;

  always_comb begin
    priv_pg     = entry[3];
    base_rights = {entry[2] | entry[1], entry[1], entry[0]};
    if (priv_pg && user_mode)
      rights = 3'b000;
    else if (priv_pg || user_mode)
      rights = base_rights;
    else
      rights = base_rights & ~key_deny;

    unique case (access)
      ACC_WRITE: need = 3'b010;
      ACC_EXEC:  need = 3'b001;
      default:   need = 3'b100;
    endcase

    guard = (access == ACC_EXEC) && (entry[5:4] == ATT_NONIDEM);
    if (guard) begin
      deny       = 1'b1;
      deny_cause = CAUSE_GUARD;
    end else if ((rights & need) == 3'b000) begin
      deny       = 1'b1;
      deny_cause = CAUSE_PROT;
    end else begin
      deny       = 1'b0;
      deny_cause = 32'h0;
    end
  end
endmodule

// File: rtl/rwalk_rc.sv
module rwalk_rc
  import rwalk_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  logic [1:0]       access,
  input  logic [2:0]       rights_in,
  output logic [ENT_W-1:0] entry_out,
  output logic             changed,
  output logic [2:0]       rights_out
);
  always_comb begin
    entry_out          = entry;
    entry_out[BIT_REF] = 1'b1;
    rights_out         = rights_in;
    if (access == ACC_WRITE)
      entry_out[BIT_CHG] = 1'b1;
    else
      rights_out[1] = 1'b0;
    changed = (entry_out != entry);
  end
endmodule

// File: rtl/rwalk_top.sv
module rwalk_top
  import rwalk_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int MAX_LEVELS = 8,
  parameter int MIN_BITS   = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [ADDR_W-1:0]         ea,
  input  logic [ADDR_W-1:0]         root_base,
  input  logic [LVL_W-1:0]          root_bits,
  input  logic [$clog2(ADDR_W)-1:0] addr_bits,
  input  logic [1:0]                access,
  input  logic                      user_mode,
  input  logic [2:0]                key_deny,
  output logic                      rd_req,
  output logic [ADDR_W-1:0]         rd_addr,
  input  logic                      rd_valid,
  input  logic [ENT_W-1:0]          rd_data,
  output logic                      wr_req,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [ENT_W-1:0]          wr_data,
  input  logic                      wr_ack,
  output logic                      done,
  output logic                      fault,
  output logic [31:0]               cause,
  output logic [ADDR_W-1:0]         real_addr,
  output logic [$clog2(ADDR_W)-1:0] page_exp,
  output logic [2:0]                perm
);
  localparam int SW = $clog2(ADDR_W);
  localparam int DW = $clog2(MAX_LEVELS + 1);

  walk_st_e          st_q;
  logic [ADDR_W-1:0] ea_q;
  logic [ADDR_W-1:0] base_q;
  logic [LVL_W-1:0]  nls_q;
  logic [SW-1:0]     rem_q;
  logic [1:0]        acc_q;
  logic              user_q;
  logic [2:0]        deny_q;
  logic [DW-1:0]     depth_q;
  logic [ENT_W-1:0]  ent_q;

  logic [ADDR_W-1:0] idx_addr;
  logic              idx_bad;
  logic              pm_deny;
  logic [31:0]       pm_cause;
  logic [2:0]        pm_rights;
  logic [ENT_W-1:0]  rc_entry;
  logic              rc_changed;
  logic [2:0]        rc_rights;
  logic [SW-1:0]     rem_left;
  logic [ADDR_W-1:0] pg_mask;
  logic [ADDR_W-1:0] leaf_ra;

  rwalk_index #(.ADDR_W(ADDR_W), .MIN_BITS(MIN_BITS)) u_index (
    .ea       (ea_q),
    .base     (base_q),
    .lvl_bits (nls_q),
    .rem_bits (rem_q),
    .ent_addr (idx_addr),
    .cfg_bad  (idx_bad)
  );

  rwalk_perm u_perm (
    .entry      (ent_q),
    .access     (acc_q),
    .user_mode  (user_q),
    .key_deny   (deny_q),
    .deny       (pm_deny),
    .deny_cause (pm_cause),
    .rights     (pm_rights)
  );

  rwalk_rc u_rc (
    .entry      (ent_q),
    .access     (acc_q),
    .rights_in  (pm_rights),
    .entry_out  (rc_entry),
    .changed    (rc_changed),
    .rights_out (rc_rights)
  );

  always_comb begin
    rem_left = rem_q - SW'(nls_q);
    pg_mask  = (ADDR_W'(1) << rem_left) - ADDR_W'(1);
    leaf_ra  = (ADDR_W'(ent_q & PAGE_NUM_MASK) & ~pg_mask) | (ea_q & pg_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      ea_q      <= '0;
      base_q    <= '0;
      nls_q     <= '0;
      rem_q     <= '0;
      acc_q     <= '0;
      user_q    <= 1'b0;
      deny_q    <= '0;
      depth_q   <= '0;
      ent_q     <= '0;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      wr_req    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      cause     <= '0;
      real_addr <= '0;
      page_exp  <= '0;
      perm      <= '0;
    end else begin
      rd_req <= 1'b0;
      wr_req <= 1'b0;
      done   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            ea_q    <= ea;
            base_q  <= root_base;
            nls_q   <= root_bits;
            rem_q   <= addr_bits;
            acc_q   <= access;
            user_q  <= user_mode;
            deny_q  <= key_deny;
            depth_q <= '0;
            st_q    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (idx_bad || (depth_q == DW'(MAX_LEVELS))) begin
            done      <= 1'b1;
            fault     <= 1'b1;
            cause     <= CAUSE_BADCFG;
            real_addr <= '0;
            page_exp  <= '0;
            perm      <= '0;
            st_q      <= ST_IDLE;
          end else begin
            rd_req  <= 1'b1;
            rd_addr <= idx_addr;
            st_q    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rd_valid) begin
            ent_q <= rd_data;
            st_q  <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (!ent_q[BIT_VALID]) begin
            done      <= 1'b1;
            fault     <= 1'b1;
            cause     <= CAUSE_NOENT;
            real_addr <= '0;
            page_exp  <= '0;
            perm      <= '0;
            st_q      <= ST_IDLE;
          end else if (ent_q[BIT_LEAF]) begin
            if (pm_deny) begin
              done      <= 1'b1;
              fault     <= 1'b1;
              cause     <= pm_cause;
              real_addr <= '0;
              page_exp  <= '0;
              perm      <= '0;
              st_q      <= ST_IDLE;
            end else begin
              fault     <= 1'b0;
              cause     <= '0;
              real_addr <= leaf_ra;
              page_exp  <= rem_left;
              perm      <= rc_rights;
              if (rc_changed) begin
                wr_req  <= 1'b1;
                wr_addr <= rd_addr;
                wr_data <= rc_entry;
                st_q    <= ST_WB;
              end else begin
                done <= 1'b1;
                st_q <= ST_IDLE;
              end
            end
          end else begin
            base_q  <= ADDR_W'(ent_q & NEXT_BASE_MASK);
            nls_q   <= ent_q[LVL_W-1:0];
            rem_q   <= rem_left;
            depth_q <= depth_q + DW'(1);
            st_q    <= ST_LOOK;
          end
        end
        ST_WB: begin
          if (wr_ack) begin
            done <= 1'b1;
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rwalk_chk.sv
module rwalk_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic [63:0]       rd_data,
  input logic              wr_req,
  input logic [63:0]       wr_data,
  input logic              done,
  input logic              fault,
  input logic [31:0]       cause,
  input logic [2:0]        perm
);
  localparam logic [63:0] RC_BITS = 64'h0000_0000_0000_0180;

  logic [63:0] last_rd;

  always_ff @(posedge clk) begin
    if (rst) last_rd <= '0;
    else if (rd_valid) last_rd <= rd_data;
  end

  a_r11_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));

  a_r1_aligned_read: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_addr[2:0] == 3'b000));

  a_r12_fault_result: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> ((perm == 3'b000) && (cause != 32'h0)));

  a_r12_ok_no_cause: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (cause == 32'h0));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_ref_set: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> wr_data[8]);

  a_r11_write_changes: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> (wr_data != last_rd));

  a_r10_only_rc_bits: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> ((wr_data & ~RC_BITS) == (last_rd & ~RC_BITS)));
endmodule

bind rwalk_top rwalk_chk #(.ADDR_W(ADDR_W)) u_rwalk_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_req   (rd_req),
  .rd_addr  (rd_addr),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .wr_req   (wr_req),
  .wr_data  (wr_data),
  .done     (done),
  .fault    (fault),
  .cause    (cause),
  .perm     (perm)
);

// File: tb/tb_rwalk_top.sv
`timescale 1ns/1ps
module tb_rwalk_top;
  localparam logic [63:0] V_BIT = 64'h8000_0000_0000_0000;
  localparam logic [63:0] L_BIT = 64'h4000_0000_0000_0000;
  localparam logic [63:0] RPN_M = 64'h01FF_FFFF_FFFF_F000;
  localparam logic [63:0] NLB_M = 64'h0FFF_FFFF_FFFF_FF00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] ea = '0;
  logic [63:0] root_base = '0;
  logic [4:0]  root_bits = '0;
  logic [5:0]  addr_bits = '0;
  logic [1:0]  access = '0;
  logic        user_mode = 1'b0;
  logic [2:0]  key_deny = '0;
  logic        rd_req;
  logic [63:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic        wr_req;
  logic [63:0] wr_addr;
  logic [63:0] wr_data;
  logic        wr_ack = 1'b0;
  logic        done;
  logic        fault;
  logic [31:0] cause;
  logic [63:0] real_addr;
  logic [5:0]  page_exp;
  logic [2:0]  perm;

  always #10 clk = ~clk;

  rwalk_top dut (
    .clk(clk), .rst(rst), .start(start), .ea(ea), .root_base(root_base),
    .root_bits(root_bits), .addr_bits(addr_bits), .access(access),
    .user_mode(user_mode), .key_deny(key_deny), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .done(done), .fault(fault), .cause(cause), .real_addr(real_addr),
    .page_exp(page_exp), .perm(perm)
  );

  logic [63:0] mem [0:4095];
  int          n_cmp = 0;
  int          n_bad = 0;
  int          rd_cnt = 0;
  int          rd_count = 0;
  logic [63:0] rd_a = '0;
  logic [63:0] first_rd = '0;
  int          wr_cnt = 0;
  logic [63:0] wr_a = '0;
  logic [63:0] wr_d = '0;
  int          wr_count = 0;
  logic [63:0] wr_seen_d = '0;
  logic [63:0] wr_seen_a = '0;

  typedef struct packed {
    logic        fault;
    logic [31:0] cause;
    logic [63:0] raddr;
    logic [5:0]  pexp;
    logic [2:0]  perm;
    logic        wr;
    logic [63:0] wdata;
    logic [63:0] waddr;
    logic [7:0]  reads;
    logic [63:0] first;
  } exp_t;

  // memory model with random latency
  always @(negedge clk) begin
    rd_valid <= 1'b0;
    wr_ack   <= 1'b0;
    if (rd_req) begin
      if (rd_count == 0) first_rd <= rd_addr;
      rd_count <= rd_count + 1;
      rd_a     <= rd_addr;
      rd_cnt   <= 1 + int'($urandom % 3);
    end else if (rd_cnt != 0) begin
      if (rd_cnt == 1) begin
        rd_valid <= 1'b1;
        rd_data  <= mem[rd_a[14:3]];
      end
      rd_cnt <= rd_cnt - 1;
    end
    if (wr_req) begin
      wr_a   <= wr_addr;
      wr_d   <= wr_data;
      wr_cnt <= 1 + int'($urandom % 3);
    end else if (wr_cnt != 0) begin
      if (wr_cnt == 1) begin
        mem[wr_a[14:3]] <= wr_d;
        wr_ack    <= 1'b1;
        wr_count  <= wr_count + 1;
        wr_seen_d <= wr_d;
        wr_seen_a <= wr_a;
      end
      wr_cnt <= wr_cnt - 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = '0;
  endtask

  function automatic logic [63:0] lvl_index(input logic [63:0] a, input int rem, input int n);
    return (a >> (rem - n)) & ((64'd1 << n) - 64'd1);
  endfunction

  task automatic ref_walk(input logic [63:0] a, input logic [63:0] b0, input int n0,
                          input int tot, input logic [1:0] acc, input logic usr,
                          input logic [2:0] dny, output exp_t r);
    logic [63:0] b, e, ne, msk, adr;
    logic [2:0]  pr, need;
    int          n, rem;
    bit          fin;
    r = '0; b = b0; n = n0; rem = tot; fin = 0;
    for (int lvl = 0; lvl <= 8 && !fin; lvl++) begin
      if (lvl == 8 || n < 5 || n > rem) begin
        r.fault = 1; r.cause = 32'h0008_0000; fin = 1;
      end else begin
        adr = b + lvl_index(a, rem, n) * 8;
        if (r.reads == 0) r.first = adr;
        r.reads++;
        e = mem[adr[14:3]];
        if (!e[63]) begin
          r.fault = 1; r.cause = 32'h4000_0000; fin = 1;
        end else begin
          rem = rem - n;
          if (e[62]) begin
            fin = 1;
            pr = {e[2] | e[1], e[1], e[0]};
            if (e[3] && usr) pr = 3'b000;
            else if (!e[3] && !usr) pr = pr & ~dny;
            need = (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b001 : 3'b100;
            if (acc == 2'd2 && e[5:4] == 2'b10) begin
              r.fault = 1; r.cause = 32'h1000_0000;
            end else if ((pr & need) == 3'b000) begin
              r.fault = 1; r.cause = 32'h0800_0000;
            end else begin
              msk = (64'd1 << rem) - 64'd1;
              r.raddr = (e & RPN_M & ~msk) | (a & msk);
              r.pexp = 6'(rem);
              ne = e | 64'h100;
              if (acc == 2'd1) ne = ne | 64'h80;
              else pr[1] = 1'b0;
              r.perm = pr;
              r.wr = (ne != e);
              r.wdata = ne;
              r.waddr = adr;
            end
          end else begin
            b = e & NLB_M;
            n = int'(e[4:0]);
          end
        end
      end
    end
  endtask

  task automatic run_case(input string tag, input logic [63:0] a, input logic [63:0] b0,
                          input int n0, input int tot, input logic [1:0] acc,
                          input logic usr, input logic [2:0] dny);
    exp_t ex;
    int   waited;
    ref_walk(a, b0, n0, tot, acc, usr, dny, ex);
    @(negedge clk);
    rd_count = 0; wr_count = 0;
    ea = a; root_base = b0; root_bits = 5'(n0); addr_bits = 6'(tot);
    access = acc; user_mode = usr; key_deny = dny; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    if (!done) begin
      chk({tag, " R12 walk ended"}, 64'd0, 64'd1);
      return;
    end
    chk({tag, " R2 R3 R4 R5 fault"}, 64'(fault), 64'(ex.fault));
    chk({tag, " R2 R3 R4 R5 R8 R9 cause"}, 64'(cause), 64'(ex.cause));
    chk({tag, " R4 R6 read count"}, 64'(rd_count), 64'(ex.reads));
    if (ex.reads != 0) chk({tag, " R1 first read address"}, first_rd, ex.first);
    chk({tag, " R7 real address"}, real_addr, ex.raddr);
    chk({tag, " R7 page exponent"}, 64'(page_exp), 64'(ex.pexp));
    chk({tag, " R8 R10 perm"}, 64'(perm), 64'(ex.perm));
    chk({tag, " R11 write-back count"}, 64'(wr_count), ex.wr ? 64'd1 : 64'd0);
    if (ex.wr && wr_count == 1) begin
      chk({tag, " R10 write data"}, wr_seen_d, ex.wdata);
      chk({tag, " R11 write address"}, wr_seen_a, ex.waddr);
    end
    @(negedge clk);
    chk({tag, " R12 done pulse"}, 64'(done), 64'd0);
  endtask

  // two-level tree: root at 0 (width l0), leaf level at 0x800 (width l1)
  task automatic put_two(input logic [63:0] a, input int tot, input int l0,
                         input int l1, input logic [63:0] leaf);
    logic [63:0] i0, i1;
    clear_mem();
    i0 = lvl_index(a, tot, l0);
    i1 = lvl_index(a, tot - l0, l1);
    mem[i0[11:0]] = V_BIT | 64'h800 | 64'(l1);
    mem[12'h100 + i1[11:0]] = leaf;
  endtask

  task automatic put_random(input logic [63:0] a, input int tot, output int l0);
    int          d, rem;
    int          l [0:3];
    logic [63:0] idx, e;
    int          bad;
    d = 1 + int'($urandom % 4);
    for (int i = 0; i < 4; i++) l[i] = 5 + int'($urandom % 4);
    bad = (($urandom % 10) == 0) ? int'($urandom % d) : -1;
    clear_mem();
    rem = tot;
    for (int i = 0; i < d; i++) begin
      idx = lvl_index(a, rem, l[i]);
      if (i < d - 1) e = V_BIT | 64'(i + 1) * 64'h800 | 64'(l[i + 1]);
      else e = V_BIT | L_BIT | ({$urandom, $urandom} & RPN_M) | 64'($urandom % 512);
      if (i == bad) e[63] = 1'b0;
      mem[12'(i * 256) + idx[11:0]] = e;
      rem = rem - l[i];
    end
    l0 = l[0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] a;
    int          l0, tot;
    process::self().srandom(32'h5eed_1234);
    clear_mem();
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 reset done", 64'(done), 64'd0);
    chk("R12 reset rd_req", 64'(rd_req), 64'd0);
    chk("R12 reset wr_req", 64'(wr_req), 64'd0);

    a = 64'h0000_00AB_CDEF_1234;
    // R2: root width 4
    run_case("D1", a, 64'h0, 4, 40, 2'd0, 1'b0, 3'b000);
    // R3: width exceeds remaining
    run_case("D2", a, 64'h0, 10, 8, 2'd0, 1'b0, 3'b000);
    // R4: nine levels of pointers
    clear_mem();
    for (int i = 0; i < 9; i++) mem[i * 256] = V_BIT | 64'(i + 1) * 64'h800 | 64'd5;
    run_case("D3 R4 depth", 64'h0, 64'h0, 5, 60, 2'd0, 1'b0, 3'b000);
    // R4: eighth level is a leaf
    mem[7 * 256] = V_BIT | L_BIT | 64'h0000_0000_0001_0000 | 64'h104;
    run_case("D3b R4 depth8", 64'h0, 64'h0, 5, 60, 2'd0, 1'b0, 3'b000);
    // R5: invalid root entry
    clear_mem();
    run_case("D4 R5", a, 64'h0, 6, 40, 2'd0, 1'b0, 3'b000);
    // R11: R already set, read -> no write
    put_two(a, 40, 6, 7, V_BIT | L_BIT | 64'h0123_4567_8000 | 64'h104);
    run_case("D5 R11 no change", a, 64'h0, 6, 40, 2'd0, 1'b0, 3'b000);
    // R8/R11: write to read-only page with R clear -> fault, no write
    put_two(a, 40, 6, 7, V_BIT | L_BIT | 64'h0123_4567_8000 | 64'h004);
    run_case("D6 R8 R11 ro write", a, 64'h0, 6, 40, 2'd1, 1'b0, 3'b000);
    // R9: exec on non-idempotent attribute
    put_two(a, 40, 6, 7, V_BIT | L_BIT | 64'h0123_4567_8000 | 64'h021);
    run_case("D7 R9 guard", a, 64'h0, 6, 40, 2'd2, 1'b0, 3'b000);
    // R8: user on privileged page
    put_two(a, 40, 6, 7, V_BIT | L_BIT | 64'h0123_4567_8000 | 64'h00E);
    run_case("D8 R8 priv", a, 64'h0, 6, 40, 2'd0, 1'b1, 3'b000);
    // R8: supervisor key deny of read
    put_two(a, 40, 6, 7, V_BIT | L_BIT | 64'h0123_4567_8000 | 64'h004);
    run_case("D9 R8 key", a, 64'h0, 6, 40, 2'd0, 1'b0, 3'b100);
    // R10: write sets R and C
    put_two(a, 40, 6, 7, V_BIT | L_BIT | 64'h0123_4567_8000 | 64'h002);
    run_case("D10 R10 write", a, 64'h0, 6, 40, 2'd1, 1'b0, 3'b000);
    // R10: exec drops write right
    put_two(a, 40, 6, 7, V_BIT | L_BIT | 64'h0123_4567_8000 | 64'h003);
    run_case("D11 R10 exec", a, 64'h0, 6, 40, 2'd2, 1'b0, 3'b000);

    for (int k = 0; k < 400; k++) begin
      a = {$urandom, $urandom};
      tot = 36 + int'($urandom % 16);
      put_random(a, tot, l0);
      run_case("RND R1 R6 R7 R8 R10 R11", a, 64'h0, l0, tot, 2'($urandom % 3),
               1'($urandom % 2), 3'($urandom % 8));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule